// File: doc/BRIEF.md
# Front-End Latency Pipeline Buffer

This block sits on one front-end channel. It writes one digitized sample per pipeline clock into a circular store, whatever else is going on. A first-level trigger decision reaches the block a fixed number of clocks after the bunch crossing it refers to. With the reference timing of a 3.2 us decision delay and a 40 MHz clock, that delay is 128 ticks, so the store holds at least that many samples. The store depth is a power of two with a default of 256.

The accept strobe is sampled on every clock. An accept selects the sample captured `cfg_latency` clocks earlier, which is the write pointer minus the latency. A copy engine then moves that sample and the samples that follow it into a readout FIFO, one word per clock. The number of samples moved per accept is set by `cfg_window` and runs from 1 to 4. A cycle without an accept moves nothing, and the old data is simply overwritten on a later lap. An accept is dropped and counted as lost in two cases: when the engine is still copying, or when the FIFO has less free room than one whole window. The `busy` output is high whenever an accept arriving in that cycle would be dropped. Words leave the FIFO over a valid/ready stream, and each word carries a flag that marks the end of its window.

The copy engine is a two-state machine. In CP_IDLE it waits. The transition T_START (accept while not busy) latches the base address and the window length and moves to CP_COPY. In CP_COPY it pushes one word per clock. The transition T_DONE, taken after the last word of the window, returns it to CP_IDLE.

Top module: `l1_pipe_buffer`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, `ro_valid` is 0, `busy` is 0 and `lost_count` is 0 until the first accept.
- R2: A sample is written on every clock edge, including while a copy is in progress and while the readout FIFO is full. After any stall, a later accept therefore still returns the correct samples.
- R3: When `l1_accept` is high at a clock edge and the accept is taken, the first word it produces is the sample captured at the edge `cfg_latency` clocks earlier. `cfg_latency` can be any value from 0 to DEPTH-1. A value of 0 selects the sample captured at the accept edge itself.
- R4: A taken accept produces N = `cfg_window` + 1 words, where `cfg_window` is 0 to 3. The words are consecutive samples in capture order. `ro_last` is 1 on the final word of the window and 0 on the others.
- R5: When no accept is taken, nothing enters the readout FIFO, and `ro_valid` stays 0 while the FIFO is empty.
- R6: An accept that arrives while a window is still being copied is dropped. It adds no words, and it increments `lost_count` by one.
- R7: An accept that arrives while the FIFO has fewer than N free entries is dropped and counted in `lost_count`. `busy` is 1 in every cycle where an accept would be dropped (copy in progress, or free room below N), and 0 otherwise.
- R8: The readout stream transfers a word on an edge where `ro_valid` and `ro_ready` are both high. While `ro_valid` is high and `ro_ready` is low, `ro_data` and `ro_last` hold their values. Words leave in the order they were written.
- R9: `lost_count` saturates at its all-ones value (255 for the default width) and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | DW | Digitized sample, captured on every edge |
| l1_accept | input | 1 | First-level accept strobe, sampled on every edge |
| cfg_latency | input | AW | Trigger latency in clocks (0 to DEPTH-1) |
| cfg_window | input | 2 | Window length minus one |
| ro_ready | input | 1 | Readout consumer ready |
| ro_valid | output | 1 | Readout word available |
| ro_data | output | DW | Readout sample |
| ro_last | output | 1 | Final word of a window |
| busy | output | 1 | An accept in this cycle would be dropped |
| lost_count | output | LOST_W | Saturating count of dropped accepts |

## Verification
The input stream is a running counter, so every readout word shows exactly which capture edge it came from. An off-by-one in the latency subtraction, a wrong window order, or a missing wrap of the ring address each shows up as a distinct wrong value. Latencies of 0, 20, 30, 40, 128 and 255 are tried with window lengths 1 to 4. Back-to-back accepts separate the drop-while-copying case from the drop-on-full-FIFO case. A long hold on a full FIFO probes three things: counter saturation, data holding under backpressure, and the fact that writing never paused.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

    typedef enum logic [0:0] {
        CP_IDLE = 1'b0,
        CP_COPY = 1'b1
    } cp_state_t;

endpackage

// File: rtl/lpb_ring.sv
module lpb_ring #(
    parameter int DW = 12,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] wptr
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wptr_q;

    // Write pointer advances on every edge, never paused.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        store[wptr_q] <= din;
    end

    assign rd_data = store[rd_addr];
    assign wptr    = wptr_q;

endmodule

// File: rtl/lpb_fifo.sv
module lpb_fifo #(
    parameter int W     = 13,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] free
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign free    = CW'(DEPTH) - cnt_q;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

endmodule

// File: rtl/lpb_copy_fsm.sv
module lpb_copy_fsm
    import lpb_pkg::*;
#(
    parameter int AW    = 8,
    parameter int WIN_W = 2,
    parameter int FCW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [AW-1:0]    cfg_latency,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic [AW-1:0]    wptr,
    input  logic [FCW-1:0]   fifo_free,
    output logic [AW-1:0]    rd_addr,
    output logic             push,
    output logic             push_last,
    output logic             busy,
    output logic             drop,
    output logic             copy_active
);
    localparam int LEN_W = WIN_W + 1;

    cp_state_t        state_q, state_d;
    logic [AW-1:0]    base_q;
    logic [WIN_W-1:0] idx_q, last_q;
    logic [LEN_W-1:0] need_len;
    logic             start;
    logic             at_last;

    assign need_len = {1'b0, cfg_window} + 1'b1;
    assign at_last  = (idx_q == last_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CP_IDLE: if (start)   state_d = CP_COPY;   // T_START
            CP_COPY: if (at_last) state_d = CP_IDLE;   // T_DONE
            default: state_d = CP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Window bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (start) begin
            base_q <= wptr - cfg_latency;
            idx_q  <= '0;
            last_q <= cfg_window;
        end else if (state_q == CP_COPY) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy        = 1'b0;
        push        = 1'b0;
        push_last   = 1'b0;
        copy_active = 1'b0;
        unique case (state_q)
            CP_IDLE: begin
                busy = (32'(fifo_free) < 32'(need_len));
            end
            CP_COPY: begin
                busy        = 1'b1;
                push        = 1'b1;
                push_last   = at_last;
                copy_active = 1'b1;
            end
            default: busy = 1'b1;
        endcase
        start   = accept && !busy;
        drop    = accept && busy;
        rd_addr = base_q + AW'(idx_q);
    end

endmodule

// File: rtl/l1_pipe_buffer.sv
module l1_pipe_buffer #(
    parameter int DW         = 12,
    parameter int AW         = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int LOST_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     smp_in,
    input  logic              l1_accept,
    input  logic [AW-1:0]     cfg_latency,
    input  logic [1:0]        cfg_window,
    input  logic              ro_ready,
    output logic              ro_valid,
    output logic [DW-1:0]     ro_data,
    output logic              ro_last,
    output logic              busy,
    output logic [LOST_W-1:0] lost_count
);
    localparam int FCW = $clog2(FIFO_DEPTH+1);
    localparam int FW  = DW + 1;

    logic [AW-1:0]  wptr, rd_addr;
    logic [DW-1:0]  rd_data;
    logic           fifo_push, fifo_push_last, fifo_full, fifo_empty;
    logic [FCW-1:0] fifo_free;
    logic [FW-1:0]  fifo_dout;
    logic           drop, copy_active;
    logic [LOST_W-1:0] lost_q;

    lpb_ring #(.DW(DW), .AW(AW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (smp_in),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wptr    (wptr)
    );

    lpb_copy_fsm #(.AW(AW), .WIN_W(2), .FCW(FCW)) u_copy (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (l1_accept),
        .cfg_latency (cfg_latency),
        .cfg_window  (cfg_window),
        .wptr        (wptr),
        .fifo_free   (fifo_free),
        .rd_addr     (rd_addr),
        .push        (fifo_push),
        .push_last   (fifo_push_last),
        .busy        (busy),
        .drop        (drop),
        .copy_active (copy_active)
    );

    lpb_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   ({fifo_push_last, rd_data}),
        .pop   (ro_ready),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .free  (fifo_free)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_q <= '0;
        end else if (drop && (lost_q != {LOST_W{1'b1}})) begin
            lost_q <= lost_q + 1'b1;
        end
    end

    assign ro_valid   = !fifo_empty;
    assign ro_data    = fifo_dout[DW-1:0];
    assign ro_last    = fifo_dout[DW];
    assign lost_count = lost_q;

endmodule

// File: rtl/lpb_checker.sv
module lpb_checker #(
    parameter int DW     = 12,
    parameter int LOST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l1_accept,
    input logic              busy,
    input logic [LOST_W-1:0] lost_count,
    input logic              ro_valid,
    input logic              ro_ready,
    input logic [DW-1:0]     ro_data,
    input logic              ro_last,
    input logic              fifo_push,
    input logic              fifo_push_last,
    input logic              fifo_full,
    input logic              copy_active
);
    localparam logic [LOST_W-1:0] LMAX = {LOST_W{1'b1}};

    AST_NO_PUSH_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_active && !l1_accept) |=> !fifo_push); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full); // R7

    AST_COPY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        copy_active |-> busy); // R6

    AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_accept && busy && lost_count != LMAX) |=> lost_count == $past(lost_count) + 1'b1); // R6

    AST_NO_SPURIOUS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!l1_accept || !busy) |=> $stable(lost_count)); // R7

    AST_LOST_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_count == LMAX) |=> lost_count == LMAX); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_valid && !ro_ready) |=> ro_valid && $stable(ro_data) && $stable(ro_last)); // R8

    AST_LAST_ENDS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_push_last) |=> !copy_active); // R4

endmodule

bind l1_pipe_buffer lpb_checker #(.DW(DW), .LOST_W(LOST_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .l1_accept      (l1_accept),
    .busy           (busy),
    .lost_count     (lost_count),
    .ro_valid       (ro_valid),
    .ro_ready       (ro_ready),
    .ro_data        (ro_data),
    .ro_last        (ro_last),
    .fifo_push      (fifo_push),
    .fifo_push_last (fifo_push_last),
    .fifo_full      (fifo_full),
    .copy_active    (copy_active)
);

// File: tb/sim_l1_pipe_buffer.sv
`timescale 1ns/1ps
module sim_l1_pipe_buffer;
    localparam int DW = 12;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] smp_in = '0;
    logic          l1_accept = 1'b0;
    logic [AW-1:0] cfg_latency = '0;
    logic [1:0]    cfg_window = '0;
    logic          ro_ready = 1'b0;
    logic          ro_valid, ro_last, busy;
    logic [DW-1:0] ro_data;
    logic [7:0]    lost_count;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [7:0] exp_lost = '0;

    always #4 clk = ~clk;

    l1_pipe_buffer u0 (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .l1_accept(l1_accept),
        .cfg_latency(cfg_latency), .cfg_window(cfg_window), .ro_ready(ro_ready),
        .ro_valid(ro_valid), .ro_data(ro_data), .ro_last(ro_last),
        .busy(busy), .lost_count(lost_count)
    );

    // Running-counter sample stream, changed at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            smp_in <= smp_in + 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_accept(output logic [DW-1:0] tag);
        @(negedge clk); #1;
        tag = smp_in;
        l1_accept = 1'b1;
        @(negedge clk); #1;
        l1_accept = 1'b0;
    endtask

    task automatic pop_window(input logic [DW-1:0] first, input int n, input string req);
        ro_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            int guard = 0;
            while (!ro_valid && guard < 40) begin
                @(negedge clk); #1;
                guard++;
            end
            check(ro_valid, req, ro_valid, 1);
            check(ro_data == first + DW'(i), req, ro_data, first + DW'(i));
            check(ro_last == (i == n-1), req, ro_last, (i == n-1));
            @(negedge clk); #1;
        end
        ro_ready = 1'b0;
    endtask

    task automatic t_reset;
        check(ro_valid == 1'b0, "R1", ro_valid, 0);
        check(busy == 1'b0, "R1", busy, 0);
        check(lost_count == 8'd0, "R1", lost_count, 0);
    endtask

    task automatic t_reject;
        int seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #1;
            if (ro_valid) seen++;
        end
        check(seen == 0, "R5", seen, 0);
    endtask

    task automatic t_single;
        logic [DW-1:0] tag;
        cfg_latency = 8'd128; cfg_window = 2'd0;
        send_accept(tag);
        pop_window(tag - DW'(128), 1, "R3");
    endtask

    task automatic t_window;
        logic [DW-1:0] tag;
        cfg_latency = 8'd20; cfg_window = 2'd3;
        send_accept(tag);
        pop_window(tag - DW'(20), 4, "R4");
    endtask

    task automatic t_latency_edges;
        logic [DW-1:0] tag;
        cfg_latency = 8'd0; cfg_window = 2'd1;
        send_accept(tag);
        pop_window(tag, 2, "R3");
        cfg_latency = 8'd255; cfg_window = 2'd0;
        send_accept(tag);
        pop_window(tag - DW'(255), 1, "R3");
    endtask

    task automatic t_overlap;
        logic [DW-1:0] t0, t1;
        int seen = 0;
        cfg_latency = 8'd30; cfg_window = 2'd3;
        send_accept(t0);
        send_accept(t1);
        exp_lost = exp_lost + 1'b1;
        check(lost_count == exp_lost, "R6", lost_count, exp_lost);
        pop_window(t0 - DW'(30), 4, "R6");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (ro_valid) seen++;
        end
        check(seen == 0, "R6", seen, 0);
    endtask

    task automatic t_full;
        logic [DW-1:0] tags [5];
        logic [DW-1:0] held;
        logic [DW-1:0] tag;
        cfg_latency = 8'd40; cfg_window = 2'd2;
        for (int k = 0; k < 5; k++) begin
            send_accept(tags[k]);
            idle(5);
        end
        check(busy == 1'b1, "R7", busy, 1);
        held = ro_data;
        idle(3);
        check(ro_valid && ro_data == held, "R8", ro_data, held);
        send_accept(tag);
        exp_lost = exp_lost + 1'b1;
        check(lost_count == exp_lost, "R7", lost_count, exp_lost);
        // Saturation of the loss counter.
        @(negedge clk); #1;
        l1_accept = 1'b1;
        idle(300);
        l1_accept = 1'b0;
        idle(1);
        check(lost_count == 8'hFF, "R9", lost_count, 8'hFF);
        for (int k = 0; k < 5; k++) begin
            pop_window(tags[k] - DW'(40), 3, "R8");
        end
        idle(2);
        check(busy == 1'b0, "R7", busy, 0);
        cfg_window = 2'd0;
        send_accept(tag);
        pop_window(tag - DW'(40), 1, "R2");
        check(lost_count == 8'hFF, "R9", lost_count, 8'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_reject();
        t_single();
        t_window();
        t_latency_edges();
        t_overlap();
        t_full();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule